// File: doc/BRIEF.md
# Bitplane Fetch Slot Sequencer

This block decides, position by position along a scanline, whether a display memory slot is spent on a bitplane fetch, and for which plane. Once a start compare match arrives, it counts through repeating fetch units of 2, 4 or 8 cycles. Inside each unit, planes are served in a fixed interleaved order. A slot whose plane is not below the configured plane limit stays idle. A stop compare match lets the current unit finish and then allows one more unit. In that final unit the plane pointers also take their modulo once a programmable cycle offset is reached.

Some fetch positions coincide with memory refresh slots. The block flags every fetch that lands on one, unless the check is switched off. The address logic downstream then advances the pointer by the refresh increment instead of the normal fetch width.

When the line ends while a unit is still unfinished, the fetch does not simply stop. The block carries the unit over into the first cycles of the next line, keeping the position in the plane order. If the stop point had not yet been passed, one further full unit is added. A new start match on the next line cuts a pending carry-over short.

Top module: `bpl_slot_seq`

## Requirements
- R1: With `unitSel` = 2'b10 or 2'b11 the unit is 8 cycles, and unit offsets 0..7 serve planes 7, 3, 5, 1, 6, 2, 4, 0.
- R2: With `unitSel` = 2'b01 the unit is 4 cycles serving planes 3, 1, 2, 0; with `unitSel` = 2'b00 it is 2 cycles serving planes 1, 0.
- R3: A slot raises `fetchStrobe` only if its plane is below `planeLimit`. Whenever `fetchStrobe` is low, `planeIdx`, `moduloAdd` and `refreshConflict` are 0.
- R4: A fetch at position 1, 3, 5 or `LINE_LEN-1` raises `refreshConflict`, unless `refreshCheckOff` is 1.
- R5: Every output is registered and reflects the inputs of the previous clock. In the normal flow, `moduloAdd` is set only in the final unit after stop, and only at offsets greater than or equal to `modCycle`.
- R6: A start match while idle makes that same cycle offset 0. A stop match finishes the current unit, runs one more unit, and then returns to idle. If the match falls on the last offset, only the one further unit follows. Start while busy and stop while idle are ignored.
- R7: If the line ends with `dmaEnable` high, fetching active and stop not yet passed, the fetch continues on the next line. It covers the rest of the unit plus one full unit, without modulo.
- R8: If the line ends after stop was passed, the remaining offsets of the unit continue on the next line with modulo. No carry-over happens when none of those offsets would fetch.
- R9: A carry-over starts in the cycle after position `LINE_LEN-1`. It continues at the offset after the one used in the last cycle of the line and wraps at the unit size.
- R10: With `dmaEnable` low no slot fetches. A carry-over is not scheduled if `dmaEnable` is low at the line end, and it is dropped when a start match begins a new fetch.
- R11: After reset all outputs are 0, fetching is idle and no carry-over is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hPos | input | HPOS_W | Horizontal beam position |
| dmaEnable | input | 1 | Bitplane DMA enable |
| startMatch | input | 1 | Fetch start compare hit at this position |
| stopMatch | input | 1 | Fetch stop compare hit at this position |
| unitSel | input | 2 | Unit size: 00 two, 01 four, 1x eight cycles |
| planeLimit | input | 4 | Number of planes in use |
| modCycle | input | 3 | First unit offset that adds the modulo |
| refreshCheckOff | input | 1 | Disables refresh collision flagging |
| fetchStrobe | output | 1 | A plane fetch occupies this slot |
| planeIdx | output | 3 | Plane served by the fetch |
| moduloAdd | output | 1 | Fetch also adds the plane modulo |
| refreshConflict | output | 1 | Fetch collides with a refresh slot |

## Verification
Every result appears exactly one clock after the position and match inputs that caused it. This includes carried-over fetches, which show up one clock after the new line's positions 0, 1, 2 and so on. The bench drives each position on a falling edge and queues the expected strobe, plane and flags at the same moment. A monitor pops that item a quarter period after the following rising edge and compares it, so each comparison is tied to one driven position. Every clock after reset goes through the driver, so the queued model and the design stay in step across line ends and carry-overs.

// File: rtl/bpl_slot_pkg.sv
package bpl_slot_pkg;

  localparam int OFF_W   = 3;
  localparam int PLANE_W = 3;
  localparam int LIMIT_W = PLANE_W + 1;
  localparam int MAX_UNIT = 1 << OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_STOP1,
    ST_STOP2
  } fetchState_t;

  // command from control to datapath, one per cycle
  typedef struct packed {
    logic             valid;
    logic [OFF_W-1:0] offset;
    logic             modEn;
  } slotCmd_t;

  function automatic logic [OFF_W:0] unitLenOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return (OFF_W+1)'(2);
      2'b01:   return (OFF_W+1)'(4);
      default: return (OFF_W+1)'(8);
    endcase
  endfunction

  // interleaved plane order within a unit
  function automatic logic [PLANE_W-1:0] planeOf(input logic [1:0] sel,
                                                 input logic [OFF_W-1:0] off);
    logic [PLANE_W-1:0] p;
    case (sel)
      2'b00: p = off[0] ? PLANE_W'(0) : PLANE_W'(1);
      2'b01:
        case (off[1:0])
          2'd0: p = PLANE_W'(3);
          2'd1: p = PLANE_W'(1);
          2'd2: p = PLANE_W'(2);
          default: p = PLANE_W'(0);
        endcase
      default:
        case (off)
          3'd0: p = PLANE_W'(7);
          3'd1: p = PLANE_W'(3);
          3'd2: p = PLANE_W'(5);
          3'd3: p = PLANE_W'(1);
          3'd4: p = PLANE_W'(6);
          3'd5: p = PLANE_W'(2);
          3'd6: p = PLANE_W'(4);
          default: p = PLANE_W'(0);
        endcase
    endcase
    return p;
  endfunction

endpackage

// File: rtl/bpl_slot_ctrl.sv
module bpl_slot_ctrl
  import bpl_slot_pkg::*;
#(
  parameter int HPOS_W   = 9,
  parameter int LINE_LEN = 227
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HPOS_W-1:0] hPos,
  input  logic              dmaEnable,
  input  logic              startMatch,
  input  logic              stopMatch,
  input  logic [1:0]        unitSel,
  input  logic [LIMIT_W-1:0] planeLimit,
  input  logic [OFF_W-1:0]  modCycle,
  output slotCmd_t          cmd
);

  localparam logic [HPOS_W-1:0] LAST_POS = HPOS_W'(LINE_LEN - 1);
  localparam int LEFT_W = OFF_W + 2;

  fetchState_t state, stateNxt, effState;
  logic [OFF_W-1:0] cnt, cntNxt, off, lastOff;
  logic [OFF_W:0]   unitLen;

  logic              ovAct, ovActNxt, ovMod, ovModNxt;
  logic [LEFT_W-1:0] ovLeft, ovLeftNxt;
  logic [OFF_W-1:0]  ovOff, ovOffNxt;

  logic lineEnd, startNow, normalAct, ovUse, lastSlot, notPassed, remNonIdle;

  always_comb begin
    unitLen   = unitLenOf(unitSel);
    lastOff   = OFF_W'(unitLen - 1'b1);
    lineEnd   = (hPos == LAST_POS);
    startNow  = (state == ST_IDLE) && startMatch && dmaEnable;
    normalAct = dmaEnable && ((state != ST_IDLE) || startMatch);
    off       = (state == ST_IDLE) ? '0 : cnt;
    lastSlot  = (off == lastOff);
    effState  = (state == ST_IDLE) ? ST_RUN : state;
    notPassed = (effState == ST_RUN) && !stopMatch;
    ovUse     = ovAct && !normalAct && dmaEnable;
  end

  // does any later offset of the unit still fetch?
  always_comb begin
    remNonIdle = 1'b0;
    for (int k = 0; k < MAX_UNIT; k++) begin
      if (k > int'(off) && k < int'(unitLen) &&
          ({1'b0, planeOf(unitSel, OFF_W'(k))} < planeLimit))
        remNonIdle = 1'b1;
    end
  end

  always_comb begin
    cmd.valid  = normalAct || ovUse;
    cmd.offset = normalAct ? off : ovOff;
    cmd.modEn  = normalAct ? ((state == ST_STOP2) && (off >= modCycle)) : ovMod;
  end

  // in-line fetch sequencing
  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    if (!dmaEnable || lineEnd) begin
      stateNxt = ST_IDLE;
      cntNxt   = '0;
    end else if (normalAct) begin
      cntNxt = lastSlot ? '0 : off + 1'b1;
      unique case (effState)
        ST_RUN:   if (stopMatch) stateNxt = lastSlot ? ST_STOP2 : ST_STOP1;
                  else           stateNxt = ST_RUN;
        ST_STOP1: stateNxt = lastSlot ? ST_STOP2 : ST_STOP1;
        ST_STOP2: stateNxt = lastSlot ? ST_IDLE : ST_STOP2;
        default:  stateNxt = ST_IDLE;
      endcase
    end
  end

  // carry-over across the line boundary
  always_comb begin
    ovActNxt  = ovAct;
    ovLeftNxt = ovLeft;
    ovOffNxt  = ovOff;
    ovModNxt  = ovMod;
    if (!dmaEnable || startNow) begin
      ovActNxt = 1'b0;
    end else if (ovUse) begin
      ovOffNxt  = (ovOff == lastOff) ? '0 : ovOff + 1'b1;
      ovLeftNxt = ovLeft - 1'b1;
      if (ovLeft == LEFT_W'(1)) ovActNxt = 1'b0;
    end
    if (lineEnd && normalAct) begin
      if (notPassed) begin
        ovActNxt  = 1'b1;
        ovLeftNxt = LEFT_W'(lastOff - off) + LEFT_W'(unitLen);
        ovOffNxt  = lastSlot ? '0 : off + 1'b1;
        ovModNxt  = 1'b0;
      end else begin
        ovActNxt  = remNonIdle;
        ovLeftNxt = LEFT_W'(lastOff - off);
        ovOffNxt  = off + 1'b1;
        ovModNxt  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      ovAct  <= 1'b0;
      ovLeft <= '0;
      ovOff  <= '0;
      ovMod  <= 1'b0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      ovAct  <= ovActNxt;
      ovLeft <= ovLeftNxt;
      ovOff  <= ovOffNxt;
      ovMod  <= ovModNxt;
    end
  end

endmodule

// File: rtl/bpl_slot_dp.sv
module bpl_slot_dp
  import bpl_slot_pkg::*;
#(
  parameter int HPOS_W        = 9,
  parameter int LINE_LEN      = 227,
  parameter int EARLY_REFRESH = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HPOS_W-1:0]  hPos,
  input  logic [1:0]         unitSel,
  input  logic [LIMIT_W-1:0] planeLimit,
  input  logic               refreshCheckOff,
  input  slotCmd_t           cmd,
  output logic               fetchStrobe,
  output logic [PLANE_W-1:0] planeIdx,
  output logic               moduloAdd,
  output logic               refreshConflict
);

  localparam logic [HPOS_W-1:0] LAST_POS = HPOS_W'(LINE_LEN - 1);

  logic [EARLY_REFRESH-1:0] earlyHit;
  logic [PLANE_W-1:0] plane;
  logic fetchNow, onRefresh;

  // early refresh slots sit at the odd positions 1, 3, 5, ...
  for (genvar i = 0; i < EARLY_REFRESH; i++) begin : gEarly
    assign earlyHit[i] = (hPos == HPOS_W'(2 * i + 1));
  end

  always_comb begin
    plane     = planeOf(unitSel, cmd.offset);
    fetchNow  = cmd.valid && ({1'b0, plane} < planeLimit);
    onRefresh = (|earlyHit) || (hPos == LAST_POS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchStrobe     <= 1'b0;
      planeIdx        <= '0;
      moduloAdd       <= 1'b0;
      refreshConflict <= 1'b0;
    end else begin
      fetchStrobe     <= fetchNow;
      planeIdx        <= fetchNow ? plane : '0;
      moduloAdd       <= fetchNow && cmd.modEn;
      refreshConflict <= fetchNow && onRefresh && !refreshCheckOff;
    end
  end

endmodule

// File: rtl/bpl_slot_seq.sv
module bpl_slot_seq
  import bpl_slot_pkg::*;
#(
  parameter int HPOS_W        = 9,
  parameter int LINE_LEN      = 227,
  parameter int EARLY_REFRESH = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HPOS_W-1:0]  hPos,
  input  logic               dmaEnable,
  input  logic               startMatch,
  input  logic               stopMatch,
  input  logic [1:0]         unitSel,
  input  logic [LIMIT_W-1:0] planeLimit,
  input  logic [OFF_W-1:0]   modCycle,
  input  logic               refreshCheckOff,
  output logic               fetchStrobe,
  output logic [PLANE_W-1:0] planeIdx,
  output logic               moduloAdd,
  output logic               refreshConflict
);

  slotCmd_t slotCmd;

  bpl_slot_ctrl #(.HPOS_W(HPOS_W), .LINE_LEN(LINE_LEN)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hPos       (hPos),
    .dmaEnable  (dmaEnable),
    .startMatch (startMatch),
    .stopMatch  (stopMatch),
    .unitSel    (unitSel),
    .planeLimit (planeLimit),
    .modCycle   (modCycle),
    .cmd        (slotCmd)
  );

  bpl_slot_dp #(.HPOS_W(HPOS_W), .LINE_LEN(LINE_LEN), .EARLY_REFRESH(EARLY_REFRESH)) uDp (
    .clk             (clk),
    .rstN            (rstN),
    .hPos            (hPos),
    .unitSel         (unitSel),
    .planeLimit      (planeLimit),
    .refreshCheckOff (refreshCheckOff),
    .cmd             (slotCmd),
    .fetchStrobe     (fetchStrobe),
    .planeIdx        (planeIdx),
    .moduloAdd       (moduloAdd),
    .refreshConflict (refreshConflict)
  );

endmodule

// File: rtl/bpl_slot_chk.sv
module bpl_slot_chk
  import bpl_slot_pkg::*;
#(
  parameter int HPOS_W        = 9,
  parameter int LINE_LEN      = 227,
  parameter int EARLY_REFRESH = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [HPOS_W-1:0]  hPos,
  input logic               dmaEnable,
  input logic [1:0]         unitSel,
  input logic [LIMIT_W-1:0] planeLimit,
  input logic               refreshCheckOff,
  input logic               fetchStrobe,
  input logic [PLANE_W-1:0] planeIdx,
  input logic               moduloAdd,
  input logic               refreshConflict
);

  localparam logic [HPOS_W-1:0] LAST_POS = HPOS_W'(LINE_LEN - 1);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !fetchStrobe |-> (planeIdx == '0) && !moduloAdd && !refreshConflict);

  p_below_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchStrobe |-> ({1'b0, planeIdx} < $past(planeLimit)));

  p_refresh_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    refreshConflict |-> !$past(refreshCheckOff) &&
      (($past(hPos) == LAST_POS) ||
       ($past(hPos[0]) && ($past(hPos) < HPOS_W'(2 * EARLY_REFRESH)))));

  p_two_cycle_planes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStrobe && ($past(unitSel) == 2'b00)) |-> (planeIdx <= PLANE_W'(1)));

  p_dma_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    fetchStrobe |-> $past(dmaEnable));

endmodule

bind bpl_slot_seq bpl_slot_chk #(
  .HPOS_W(HPOS_W), .LINE_LEN(LINE_LEN), .EARLY_REFRESH(EARLY_REFRESH)
) uChk (
  .clk             (clk),
  .rstN            (rstN),
  .hPos            (hPos),
  .dmaEnable       (dmaEnable),
  .unitSel         (unitSel),
  .planeLimit      (planeLimit),
  .refreshCheckOff (refreshCheckOff),
  .fetchStrobe     (fetchStrobe),
  .planeIdx        (planeIdx),
  .moduloAdd       (moduloAdd),
  .refreshConflict (refreshConflict)
);

// File: tb/bpl_slot_seq_test.sv
`timescale 1ns/1ps
module bpl_slot_seq_test;

  localparam int HPOS_W   = 9;
  localparam int LINE_LEN = 227;
  localparam int LAST     = LINE_LEN - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [HPOS_W-1:0] hPos = '0;
  logic dmaEnable = 1'b0, startMatch = 1'b0, stopMatch = 1'b0, refreshCheckOff = 1'b0;
  logic [1:0] unitSel = 2'b10;
  logic [3:0] planeLimit = 4'd8;
  logic [2:0] modCycle = 3'd0;
  logic fetchStrobe, moduloAdd, refreshConflict;
  logic [2:0] planeIdx;

  always #10 clk = ~clk;

  bpl_slot_seq #(.HPOS_W(HPOS_W), .LINE_LEN(LINE_LEN)) uut (
    .clk(clk), .rstN(rstN), .hPos(hPos), .dmaEnable(dmaEnable),
    .startMatch(startMatch), .stopMatch(stopMatch), .unitSel(unitSel),
    .planeLimit(planeLimit), .modCycle(modCycle), .refreshCheckOff(refreshCheckOff),
    .fetchStrobe(fetchStrobe), .planeIdx(planeIdx), .moduloAdd(moduloAdd),
    .refreshConflict(refreshConflict)
  );

  typedef struct {
    bit    f;
    int    pl;
    bit    m;
    bit    c;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  string curTag = "";
  bit cfgDma = 0, cfgRefOff = 0;
  int cfgUnit = 2, cfgLim = 8, cfgMod = 0;

  // reference state: 0 idle, 1 run, 2 stop seen, 3 final unit
  int mState = 0, mCnt = 0, mOvAct = 0, mOvLeft = 0, mOvOff = 0, mOvMod = 0;

  function automatic int unitLen(int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
  endfunction

  // plane order = bit reversal of the count down within the unit
  function automatic int refPlane(int u, int o);
    int x = (u - 1) - o;
    if (u == 8) return ((x & 1) << 2) | (x & 2) | ((x >> 2) & 1);
    if (u == 4) return ((x & 1) << 1) | ((x >> 1) & 1);
    return x;
  endfunction

  task automatic step(input int h, input bit sM, input bit pM);
    exp_t e;
    int u, off, o, pl, effS, nOvAct, nOvLeft, nOvOff, nOvMod;
    bit nAct, ovUse, valid, modEn, lastS, anyLeft;
    @(negedge clk);
    hPos = HPOS_W'(h); startMatch = sM; stopMatch = pM; dmaEnable = cfgDma;
    unitSel = 2'(cfgUnit); planeLimit = 4'(cfgLim); modCycle = 3'(cfgMod);
    refreshCheckOff = cfgRefOff;
    u = unitLen(cfgUnit);
    nAct  = cfgDma && (mState != 0 || sM);
    off   = (mState == 0) ? 0 : mCnt;
    ovUse = (mOvAct != 0) && !nAct && cfgDma;
    valid = nAct || ovUse;
    o     = nAct ? off : mOvOff;
    modEn = nAct ? (mState == 3 && off >= cfgMod) : (mOvMod != 0);
    pl    = refPlane(u, o);
    e.f   = valid && (pl < cfgLim);
    e.pl  = e.f ? pl : 0;
    e.m   = e.f && modEn;
    e.c   = e.f && !cfgRefOff && (h == 1 || h == 3 || h == 5 || h == LAST);
    e.tag = curTag;
    q.push_back(e);
    // carry-over bookkeeping
    nOvAct = mOvAct; nOvLeft = mOvLeft; nOvOff = mOvOff; nOvMod = mOvMod;
    if (!cfgDma || (sM && mState == 0)) nOvAct = 0;
    else if (ovUse) begin
      nOvOff = (mOvOff == u - 1) ? 0 : mOvOff + 1;
      nOvLeft = mOvLeft - 1;
      if (mOvLeft == 1) nOvAct = 0;
    end
    lastS = (off == u - 1);
    effS  = (mState == 0) ? 1 : mState;
    if (h == LAST && nAct) begin
      if (effS == 1 && !pM) begin
        nOvAct = 1; nOvLeft = (u - 1 - off) + u; nOvOff = lastS ? 0 : off + 1; nOvMod = 0;
      end else begin
        anyLeft = 0;
        for (int k = off + 1; k < u; k++) if (refPlane(u, k) < cfgLim) anyLeft = 1;
        nOvAct = anyLeft; nOvLeft = u - 1 - off; nOvOff = off + 1; nOvMod = 1;
      end
    end
    mOvAct = nOvAct; mOvLeft = nOvLeft; mOvOff = nOvOff; mOvMod = nOvMod;
    // in-line sequencing
    if (!cfgDma || h == LAST) begin mState = 0; mCnt = 0; end
    else if (nAct) begin
      mCnt = lastS ? 0 : off + 1;
      if (effS == 1)      mState = pM ? (lastS ? 3 : 2) : 1;
      else if (effS == 2) mState = lastS ? 3 : 2;
      else                mState = lastS ? 0 : 3;
    end
  endtask

  task automatic runSpan(input int from, input int to, input int sPos, input int pPos);
    for (int h = from; h <= to; h++) step(h, h == sPos, h == pPos);
  endtask

  task automatic quiet();
    cfgDma = 0;
    for (int i = 0; i < 3; i++) step(100, 0, 0);
  endtask

  // monitor: compare one queued item per clock
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (fetchStrobe !== e.f || int'(planeIdx) != e.pl || moduloAdd !== e.m ||
            refreshConflict !== e.c) begin
          errors++;
          $display("FAIL %s: got f=%0b p=%0d m=%0b c=%0b expected f=%0b p=%0d m=%0b c=%0b",
                   e.tag, fetchStrobe, planeIdx, moduloAdd, refreshConflict,
                   e.f, e.pl, e.m, e.c);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (fetchStrobe !== 1'b0 || planeIdx !== 3'd0 || moduloAdd !== 1'b0 || refreshConflict !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: got f=%0b p=%0d m=%0b c=%0b expected all 0",
               fetchStrobe, planeIdx, moduloAdd, refreshConflict);
    end

    curTag = "R10 R11 DMA off ignores start";
    cfgDma = 0; runSpan(0, 10, 2, 5);

    curTag = "R1 R5 R6 eight-cycle unit"; cfgDma = 1; cfgUnit = 2; cfgLim = 8; cfgMod = 0;
    runSpan(10, 45, 16, 30); quiet();

    curTag = "R1 R5 code 11 modulo threshold"; cfgDma = 1; cfgUnit = 3; cfgMod = 5;
    runSpan(60, 85, 62, 64); quiet();

    curTag = "R2 R3 R5 four-cycle limit 2"; cfgDma = 1; cfgUnit = 1; cfgLim = 2; cfgMod = 2;
    runSpan(90, 110, 92, 97); quiet();

    curTag = "R2 R6 two-cycle stop on last offset"; cfgDma = 1; cfgUnit = 0; cfgLim = 2; cfgMod = 1;
    runSpan(120, 135, 121, 124); quiet();

    curTag = "R4 refresh slots"; cfgDma = 1; cfgUnit = 2; cfgLim = 8; cfgMod = 0;
    runSpan(0, 20, 0, 3); quiet();

    curTag = "R4 refresh check off"; cfgDma = 1; cfgRefOff = 1;
    runSpan(0, 20, 0, 3); quiet(); cfgRefOff = 0;

    curTag = "R7 R9 carry-over before stop"; cfgDma = 1; cfgUnit = 2; cfgLim = 8;
    runSpan(200, 226, 216, -1); runSpan(0, 25, -1, -1); quiet();

    curTag = "R8 R9 carry-over after stop"; cfgDma = 1; cfgMod = 3;
    runSpan(205, 226, 213, 215); runSpan(0, 10, -1, -1); quiet();

    curTag = "R8 nothing left at line end"; cfgDma = 1;
    runSpan(205, 226, 211, 213); runSpan(0, 10, -1, -1); quiet();

    curTag = "R7 R3 four-cycle carry-over limit 3"; cfgDma = 1; cfgUnit = 1; cfgLim = 3; cfgMod = 0;
    runSpan(210, 226, 220, -1); runSpan(0, 12, -1, -1); quiet();

    curTag = "R10 carry-over cut by start"; cfgDma = 1; cfgUnit = 2; cfgLim = 8;
    runSpan(200, 226, 216, -1); runSpan(0, 20, 2, 10); quiet();

    curTag = "R10 DMA low at line end"; cfgDma = 1;
    runSpan(200, 225, 216, -1); cfgDma = 0; step(226, 0, 0); cfgDma = 1;
    runSpan(0, 15, -1, -1); quiet();

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule